// File: doc/BRIEF.md
# Sleep-Mode Edge Interrupt Recorder

This block sits between a set of external interrupt lines and a main interrupt controller that can be powered down. With its enable bit clear it is transparent: each output line follows its input line combinationally. Before the main controller loses power, software sets the enable and edge-record bits. While they are set, any active edge on an unmasked, edge-sensitive line is latched into a per-line recorded-status bit, and the outputs are held quiet.

When the main controller is powered again, software writes the flush bit. Every line with a recorded bit then produces one single-cycle pulse toward the parent, and those recorded bits clear in the same cycle. After that, software clears the enable bit and the block is transparent again. Per-line attributes (mask, sense, polarity) are held in banks with separate write-one-to-set and write-one-to-clear addresses. Recorded bits are cleared individually through an acknowledge address, which also reads back the recorded bits.

Top module: `edge_keep_irq`

## Requirements
- R1: Line n is held in bit (n mod 32) of the 32-bit word at bank base + 4*(n/32). Bank bases are: acknowledge/status 0x40, mask set 0xC0, mask clear 0x100, sense set 0x180, sense clear 0x1C0, polarity set 0x240, polarity clear 0x280, control 0x300. Bits above the last line read 0.
- R2: A 1 written to a set address sets that line's attribute, and a 1 written to a clear address clears it. Zero bits change nothing. Both addresses of a pair read back the current attribute.
- R3: After reset every line is masked (mask=1), sense, polarity and recorded status are 0, and the control word reads 0.
- R4: A line's status bit is set only when enable (control bit 0) and edge-record (control bit 1) are both 1, the line is unmasked, and its sense is 0 (edge). A masked line or a line with sense 1 (level) is never recorded.
- R5: With polarity 1 a rising edge is recorded; with polarity 0 a falling edge is recorded. The opposite edge is ignored.
- R6: Writing control with bit 2 set gives, in the cycle after the write, a one-cycle pulse on every output whose status bit was set. Those status bits clear at the same edge. Control bit 2 always reads 0.
- R7: A 1 written to the acknowledge address clears that line's status bit. An edge captured in the same cycle as its acknowledge is kept.
- R8: With enable 0, every output equals its input combinationally and no edge is recorded.
- R9: With enable 1, the outputs carry only flush pulses and do not follow the inputs.
- R10: Inputs pass through a two-flop synchronizer before edge detection. Reading the acknowledge address returns the recorded status. Reading the control address returns edge-record in bit 1 and enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read enable; read data is combinational |
| busAddr | input | 12 | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, 0 when busRdEn is low |
| irqIn | input | NUM_LINES | Interrupt lines from the sources |
| irqOut | output | NUM_LINES | Interrupt lines toward the parent controller |

## Verification
The bench sends an acknowledge whose write edge is the same edge at which a fresh edge on that line is captured. A design that gives the clear priority would silently lose that interrupt. It drives the wrong-direction edge on a rising-polarity line, a falling edge on a level-sense line and an edge on a masked line, any of which would show up as a spurious status bit if the qualification were incomplete. It checks that flush pulses last exactly one cycle, reach only recorded lines (including a line in the second word), and leave the status empty. It also checks that the flush bit reads back 0 and that a zero write leaves a bank unchanged.

// File: rtl/edge_keep_pkg.sv
package edge_keep_pkg;

  // Bank code is byte address bits [11:6]; these values are fixed by software.
  localparam logic [5:0] BANK_ACK      = 6'h01;
  localparam logic [5:0] BANK_MASK_SET = 6'h03;
  localparam logic [5:0] BANK_MASK_CLR = 6'h04;
  localparam logic [5:0] BANK_SENS_SET = 6'h06;
  localparam logic [5:0] BANK_SENS_CLR = 6'h07;
  localparam logic [5:0] BANK_POL_SET  = 6'h09;
  localparam logic [5:0] BANK_POL_CLR  = 6'h0A;
  localparam logic [5:0] BANK_CTRL     = 6'h0C;

  typedef struct packed {
    logic maskSet;
    logic maskClr;
    logic senseSet;
    logic senseClr;
    logic polSet;
    logic polClr;
    logic ack;
    logic flush;
    logic enable;
    logic edgeMode;
  } strobeT;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_SENSE,
    SEL_POL,
    SEL_CTRL
  } rdSelT;

endpackage

// File: rtl/edge_keep_ctrl.sv
module edge_keep_ctrl
  import edge_keep_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [9:0]        addrWord,
  input  logic [2:0]        ctrlWrBits,
  input  logic [DATA_W-1:0] bankRdData,
  output strobeT            strb,
  output rdSelT             rdSel,
  output logic [3:0]        wordSel,
  output logic [DATA_W-1:0] busRdData
);

  logic [5:0] bankCode;
  logic       enReg;
  logic       edgeReg;
  logic       ctrlWr;

  assign bankCode = addrWord[9:4];
  assign wordSel  = addrWord[3:0];
  assign ctrlWr   = busWrEn && (bankCode == BANK_CTRL) && (wordSel == 4'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg   <= 1'b0;
      edgeReg <= 1'b0;
    end else if (ctrlWr) begin
      enReg   <= ctrlWrBits[0];
      edgeReg <= ctrlWrBits[1];
    end
  end

  always_comb begin
    strb          = '0;
    strb.maskSet  = busWrEn && (bankCode == BANK_MASK_SET);
    strb.maskClr  = busWrEn && (bankCode == BANK_MASK_CLR);
    strb.senseSet = busWrEn && (bankCode == BANK_SENS_SET);
    strb.senseClr = busWrEn && (bankCode == BANK_SENS_CLR);
    strb.polSet   = busWrEn && (bankCode == BANK_POL_SET);
    strb.polClr   = busWrEn && (bankCode == BANK_POL_CLR);
    strb.ack      = busWrEn && (bankCode == BANK_ACK);
    strb.flush    = ctrlWr && ctrlWrBits[2];
    strb.enable   = enReg;
    strb.edgeMode = edgeReg;
  end

  always_comb begin
    unique case (bankCode)
      BANK_ACK:                     rdSel = SEL_STATUS;
      BANK_MASK_SET, BANK_MASK_CLR: rdSel = SEL_MASK;
      BANK_SENS_SET, BANK_SENS_CLR: rdSel = SEL_SENSE;
      BANK_POL_SET, BANK_POL_CLR:   rdSel = SEL_POL;
      BANK_CTRL:                    rdSel = (wordSel == 4'd0) ? SEL_CTRL : SEL_NONE;
      default:                      rdSel = SEL_NONE;
    endcase
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      if (rdSel == SEL_CTRL) busRdData = {{(DATA_W-2){1'b0}}, edgeReg, enReg};
      else                   busRdData = bankRdData;
    end
  end

  // R1: a single write touches at most one attribute bank
  p_one_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.maskSet, strb.maskClr, strb.senseSet, strb.senseClr,
              strb.polSet, strb.polClr, strb.ack}));

  // R6: the flush command never reads back as set
  p_flush_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && rdSel == SEL_CTRL) |-> (busRdData[2] == 1'b0));

endmodule

// File: rtl/edge_keep_datapath.sv
module edge_keep_datapath
  import edge_keep_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobeT               strb,
  input  rdSelT                rdSel,
  input  logic [3:0]           wordSel,
  input  logic [DATA_W-1:0]    busWrData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] irqOut,
  output logic [DATA_W-1:0]    bankRdData
);

  localparam int NUM_WORDS = (NUM_LINES + DATA_W - 1) / DATA_W;
  localparam int PAD_W     = NUM_WORDS * DATA_W;

  logic [NUM_LINES-1:0] maskReg, senseReg, polReg, statusReg, pulseReg;
  logic [NUM_LINES-1:0] syncA, syncB, prevB;
  logic [NUM_LINES-1:0] wrHit;
  logic [NUM_LINES-1:0] edgeHit, capture;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LINES; gi++) begin : g_line
      localparam int WORD_IDX = gi / DATA_W;
      localparam int BIT_IDX  = gi % DATA_W;
      assign wrHit[gi] = (wordSel == 4'(WORD_IDX)) && busWrData[BIT_IDX];
    end
  endgenerate

  assign edgeHit = (polReg & syncB & ~prevB) | (~polReg & ~syncB & prevB);
  assign capture = {NUM_LINES{strb.enable && strb.edgeMode}} & ~maskReg & ~senseReg & edgeHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= irqIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg  <= '1;
      senseReg <= '0;
      polReg   <= '0;
    end else begin
      if (strb.maskSet)  maskReg  <= maskReg | wrHit;
      if (strb.maskClr)  maskReg  <= maskReg & ~wrHit;
      if (strb.senseSet) senseReg <= senseReg | wrHit;
      if (strb.senseClr) senseReg <= senseReg & ~wrHit;
      if (strb.polSet)   polReg   <= polReg | wrHit;
      if (strb.polClr)   polReg   <= polReg & ~wrHit;
    end
  end

  logic [NUM_LINES-1:0] ackClr;
  assign ackClr = strb.ack ? wrHit : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusReg <= '0;
      pulseReg  <= '0;
    end else begin
      pulseReg  <= strb.flush ? statusReg : '0;
      statusReg <= (statusReg & ~ackClr & ~{NUM_LINES{strb.flush}}) | capture;
    end
  end

  assign irqOut = strb.enable ? pulseReg : irqIn;

  logic [PAD_W-1:0] padSel;
  always_comb begin
    unique case (rdSel)
      SEL_STATUS: padSel = PAD_W'(statusReg);
      SEL_MASK:   padSel = PAD_W'(maskReg);
      SEL_SENSE:  padSel = PAD_W'(senseReg);
      SEL_POL:    padSel = PAD_W'(polReg);
      default:    padSel = '0;
    endcase
    if (32'(wordSel) < NUM_WORDS) bankRdData = padSel[32'(wordSel)*DATA_W +: DATA_W];
    else                          bankRdData = '0;
  end

  // R4: a newly recorded line was unmasked in the cycle it was captured
  p_masked_no_record_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((statusReg & ~$past(statusReg) & $past(maskReg)) == '0));

  // R8: nothing is recorded while the block was disabled
  p_disabled_no_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strb.enable) |-> ((statusReg & ~$past(statusReg)) == '0));

  // R6: pulses toward the parent only follow a flush command
  p_pulse_after_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulseReg) |-> $past(strb.flush));

  // R6: after a flush only fresh captures remain recorded
  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.flush) |-> ((statusReg & ~$past(capture)) == '0));

endmodule

// File: rtl/edge_keep_irq.sv
module edge_keep_irq
  import edge_keep_pkg::*;
#(
  parameter int NUM_LINES = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busWrEn,
  input  logic                 busRdEn,
  input  logic [11:0]          busAddr,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic [NUM_LINES-1:0] irqOut
);

  localparam int DATA_W = 32;

  strobeT            strb;
  rdSelT             rdSel;
  logic [3:0]        wordSel;
  logic [DATA_W-1:0] bankRdData;

  edge_keep_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .addrWord   (busAddr[11:2]),
    .ctrlWrBits (busWrData[2:0]),
    .bankRdData (bankRdData),
    .strb       (strb),
    .rdSel      (rdSel),
    .wordSel    (wordSel),
    .busRdData  (busRdData)
  );

  edge_keep_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .rdSel      (rdSel),
    .wordSel    (wordSel),
    .busWrData  (busWrData),
    .irqIn      (irqIn),
    .irqOut     (irqOut),
    .bankRdData (bankRdData)
  );

endmodule

// File: tb/edge_keep_irq_test.sv
`timescale 1ns/1ps
module edge_keep_irq_test;

  localparam int N = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busWrEn = 1'b0;
  logic          busRdEn = 1'b0;
  logic [11:0]   busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic [N-1:0]  irqIn = '0;
  logic [N-1:0]  irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  edge_keep_irq #(.NUM_LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqIn(irqIn), .irqOut(irqOut)
  );

  always #2.5 clk = ~clk;

  // {write addr, write data, read addr, expected read, requirement number}
  localparam int NV = 9;
  localparam logic [91:0] VEC [NV] = '{
    {12'h100, 32'h0000_00FF, 12'h0C0, 32'hFFFF_FF00, 4'd2},
    {12'h0C0, 32'h0000_0001, 12'h100, 32'hFFFF_FF01, 4'd2},
    {12'h0C0, 32'h0000_0000, 12'h0C0, 32'hFFFF_FF01, 4'd2},
    {12'h104, 32'h0000_0080, 12'h0C4, 32'h0000_007F, 4'd1},
    {12'h180, 32'h0000_000C, 12'h1C0, 32'h0000_000C, 4'd2},
    {12'h1C0, 32'h0000_0004, 12'h180, 32'h0000_0008, 4'd2},
    {12'h240, 32'h0000_00F0, 12'h280, 32'h0000_00F0, 4'd2},
    {12'h280, 32'h0000_0030, 12'h240, 32'h0000_00C0, 4'd2},
    {12'h244, 32'h0000_0080, 12'h284, 32'h0000_0080, 4'd1}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1;
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R3: reset state
    busRead(12'h0C0, rd); check("R3 mask w0", 64'(rd), 64'hFFFF_FFFF);
    busRead(12'h0C4, rd); check("R3 mask w1", 64'(rd), 64'h0000_00FF);
    busRead(12'h180, rd); check("R3 sense",   64'(rd), 64'h0);
    busRead(12'h240, rd); check("R3 pol",     64'(rd), 64'h0);
    busRead(12'h040, rd); check("R3 status",  64'(rd), 64'h0);
    busRead(12'h300, rd); check("R3 control", 64'(rd), 64'h0);
    check("R3 passthrough out", 64'(irqOut), 64'(irqIn));

    // R1 R2: set/clear pair table
    for (int v = 0; v < NV; v++) begin
      busWrite(VEC[v][91:80], VEC[v][79:48]);
      busRead(VEC[v][47:36], rd);
      check($sformatf("R%0d vector %0d", VEC[v][3:0], v), 64'(rd), 64'(VEC[v][35:4]));
    end
    // State now: line0 masked, lines 1..7 and 39 unmasked, line3 level,
    // lines 6,7,39 rising polarity, others falling.

    // R8: disabled means combinational pass-through and no recording
    irqIn = 40'h00_0000_003E;
    #1 check("R8 follow input", 64'(irqOut), 64'(irqIn));
    idle(2);
    irqIn[6] = 1'b1;
    #1 check("R8 follow toggle", 64'(irqOut), 64'(irqIn));
    idle(4);
    irqIn[6] = 1'b0;
    idle(4);
    busRead(12'h040, rd); check("R8 nothing recorded", 64'(rd), 64'h0);

    // R10: enable with edge-record mode, control reads back
    busWrite(12'h300, 32'h3);
    busRead(12'h300, rd); check("R10 control readback", 64'(rd), 64'h3);

    // R4 R5: qualifying and non-qualifying edges
    irqIn[0]  = 1'b1;  // masked line
    irqIn[6]  = 1'b1;  // rising on rising polarity
    irqIn[39] = 1'b1;  // rising on rising polarity, second word
    irqIn[4]  = 1'b0;  // falling on falling polarity
    irqIn[3]  = 1'b0;  // falling on a level-sense line
    idle(5);
    check("R9 outputs quiet while enabled", 64'(irqOut), 64'h0);
    busRead(12'h040, rd); check("R4 status w0", 64'(rd), 64'h50);
    busRead(12'h044, rd); check("R4 status w1", 64'(rd), 64'h80);

    // R7: acknowledge clears one line
    busWrite(12'h040, 32'h40);
    busRead(12'h040, rd); check("R7 ack clears", 64'(rd), 64'h10);

    // R5: falling edge on a rising-polarity line ignored
    irqIn[6] = 1'b0;
    idle(5);
    busRead(12'h040, rd); check("R5 wrong edge ignored", 64'(rd), 64'h10);

    // R6: flush pulses recorded lines for one cycle
    busWrite(12'h300, 32'h7);
    check("R6 pulse lines", 64'(irqOut), 64'(40'h80_0000_0010));
    idle(1);
    check("R6 pulse one cycle", 64'(irqOut), 64'h0);
    busRead(12'h040, rd); check("R6 status cleared w0", 64'(rd), 64'h0);
    busRead(12'h044, rd); check("R6 status cleared w1", 64'(rd), 64'h0);
    busRead(12'h300, rd); check("R6 flush self-clears", 64'(rd), 64'h3);

    // R7: capture coincident with acknowledge is kept (two sync flops, then capture)
    irqIn[7] = 1'b1;
    idle(2);
    busWrite(12'h040, 32'h80);
    busRead(12'h040, rd); check("R7 edge beats ack", 64'(rd), 64'h80);

    // R8: disable returns to pass-through
    busWrite(12'h300, 32'h0);
    #1 check("R8 pass-through restored", 64'(irqOut), 64'(irqIn));

    finishRun();
  end

endmodule